// File: doc/BRIEF.md
# Flash Code Array Programming Sequencer

This block is the parallel programming port of a small on-chip code store. An external programmer presents an address, a data byte and a three-bit operation code, raises the programming-voltage enable and then strobes an active-low program line. The block carries out each byte write and each lock-bit write on its own timer. While that timer runs it holds a ready line low and answers reads of the byte being written with the inverse of that byte's top bit, so the programmer can poll for completion. Holding the strobe low in erase mode for a long enough window clears the whole store to ones and releases the locks.

Program cells only ever move from one to zero. Rewriting a byte that is not blank stores the AND of the old and new values and raises an error flag. A later erase is what restores such a byte. Once either lock bit is set, verify reads return all ones, and the lock bits have no read path of their own. A fixed three-byte identity block can be read at any time. The write and erase windows are parameters, so that simulation can shorten them.

Top module: `flash_prog_seq`

## Requirements
- R1: After reset, ready is 1, progErr is 0, every array byte reads 8'hFF and both lock bits are clear.
- R2: Operation codes are 3'd0 idle, 3'd1 byte write, 3'd2 verify read, 3'd3 lock bit A, 3'd4 lock bit B, 3'd5 erase and 3'd6 identity read. A byte write starts on the first clock edge that samples progN high when the previous edge sampled it low, with the mode set to 3'd1 and hvEn at 1. ready is 0 after that edge and for exactly WRITE_CYCLES edges, and is 1 again after the next edge.
- R3: A strobe has no effect when hvEn is 0 or when the mode is not a programming mode (3'd1, 3'd3 or 3'd4). ready stays 1 and the array is unchanged.
- R4: While a write is busy, a verify read of the address being written returns {~d[7], d[6:0]}, where d is the written byte. After completion, the same read returns the stored byte.
- R5: A write stores old AND new. progErr goes to 1 when a write starts on a byte that is not 8'hFF. It returns to 0 when a write starts on a blank byte, or on an erase.
- R6: Strobes that arrive while busy are ignored. They neither restart the timer nor change the target address or data.
- R7: In mode 3'd5 with hvEn at 1, when progN has been sampled low on ERASE_CYCLES consecutive edges while not busy, every byte becomes 8'hFF, both locks clear and progErr clears. A shorter hold changes nothing.
- R8: Lock writes (mode 3'd3 or 3'd4) follow the same timed sequence as byte writes. After either lock is set, verify reads return 8'hFF at every address.
- R9: In mode 3'd6, address 8'h30 reads 8'h1E and 8'h31 reads 8'h51. 8'h32 reads 8'hFF when HV_PART is 1, and 8'h05 otherwise. Every other address reads 8'hFF. The locks do not affect these reads.
- R10: In every mode other than 3'd2 and 3'd6, dataOut is 8'hFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| addr | input | AW | Byte address |
| dataIn | input | 8 | Byte to program |
| mode | input | 3 | Operation code |
| hvEn | input | 1 | Programming-voltage enable |
| progN | input | 1 | Active-low program strobe |
| dataOut | output | 8 | Read data, polling value or identity byte |
| ready | output | 1 | 1 when idle, 0 while a timed write runs |
| progErr | output | 1 | Last write targeted a byte that was not blank |

## Verification
The assertions assume that progN, mode, hvEn, addr and dataIn change only between clock edges. They also assume that progN rests high after reset, so that the first sampled rise is a real strobe. The stimulus changes every input one time unit after a rising edge, releases reset with the strobe high and idle mode selected, and keeps each strobe pulse at least one clock long. The erase hold and the back-to-back strobes are timed against the shortened window parameters, so that each edge case falls on a known cycle.

// File: rtl/flash_prog_pkg.sv
package flash_prog_pkg;

  typedef enum logic [2:0] {
    MODE_IDLE   = 3'd0,
    MODE_WRITE  = 3'd1,
    MODE_VERIFY = 3'd2,
    MODE_LOCKA  = 3'd3,
    MODE_LOCKB  = 3'd4,
    MODE_ERASE  = 3'd5,
    MODE_IDENT  = 3'd6
  } prog_mode_e;

  // Strobes sent from the control unit to the datapath
  typedef struct packed {
    logic latch;     // capture address, data and kind of operation
    logic commit;    // timed write finished: update the cell or lock
    logic eraseAll;  // erase window reached
  } ctrl_strobe_t;

  localparam logic [7:0] BLANK_BYTE = 8'hFF;

  function automatic logic [7:0] identByte(input logic [7:0] a, input bit hvPart);
    case (a)
      8'h30:   identByte = 8'h1E;
      8'h31:   identByte = 8'h51;
      8'h32:   identByte = hvPart ? 8'hFF : 8'h05;
      default: identByte = BLANK_BYTE;
    endcase
  endfunction

endpackage

// File: rtl/flash_prog_ctrl.sv
module flash_prog_ctrl
  import flash_prog_pkg::*;
#(
  parameter int WRITE_CYCLES = 1500,
  parameter int ERASE_CYCLES = 10000
) (
  input  logic         clk,
  input  logic         rstN,
  input  prog_mode_e   modeSel,
  input  logic         hvEn,
  input  logic         progN,
  output logic         busy,
  output ctrl_strobe_t strb
);

  localparam int WCNT_W = $clog2(WRITE_CYCLES + 1);
  localparam int ECNT_W = $clog2(ERASE_CYCLES + 1);

  logic              progPrev;
  logic [WCNT_W-1:0] wCnt;
  logic [ECNT_W-1:0] eCnt;
  logic              progRise;
  logic              isProgMode;
  logic              startOk;
  logic              eraseCond;

  assign progRise   = progN & ~progPrev;
  assign isProgMode = (modeSel == MODE_WRITE) || (modeSel == MODE_LOCKA) ||
                      (modeSel == MODE_LOCKB);
  assign startOk    = progRise && hvEn && isProgMode && !busy;
  assign eraseCond  = !progN && hvEn && (modeSel == MODE_ERASE) && !busy;

  assign strb.latch    = startOk;
  assign strb.commit   = busy && (wCnt == WCNT_W'(0));
  assign strb.eraseAll = eraseCond && (eCnt == ECNT_W'(ERASE_CYCLES - 1));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      progPrev <= 1'b1;
    end else begin
      progPrev <= progN;
    end
  end

  // Self-timed write window
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busy <= 1'b0;
      wCnt <= '0;
    end else if (startOk) begin
      busy <= 1'b1;
      wCnt <= WCNT_W'(WRITE_CYCLES - 1);
    end else if (busy) begin
      if (wCnt == WCNT_W'(0)) begin
        busy <= 1'b0;
      end else begin
        wCnt <= wCnt - WCNT_W'(1);
      end
    end
  end

  // Erase hold counter, saturating so one hold erases once
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      eCnt <= '0;
    end else if (!eraseCond) begin
      eCnt <= '0;
    end else if (eCnt != ECNT_W'(ERASE_CYCLES)) begin
      eCnt <= eCnt + ECNT_W'(1);
    end
  end

  AST_START_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(progN) && hvEn && (modeSel == MODE_WRITE) && !busy) |=> busy); // R2
  AST_WINDOW_HELD: assert property (@(posedge clk) disable iff (!rstN)
    (busy && (wCnt != WCNT_W'(0))) |=> busy); // R2
  AST_WINDOW_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> (wCnt < WCNT_W'(WRITE_CYCLES))); // R2
  AST_NO_IDLE_START: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && !hvEn) |=> !busy); // R3
  AST_ERASE_NOT_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    strb.eraseAll |-> !busy); // R7

endmodule

// File: rtl/flash_prog_dp.sv
module flash_prog_dp
  import flash_prog_pkg::*;
#(
  parameter int AW      = 6,
  parameter bit HV_PART = 1'b1
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic [AW-1:0] addr,
  input  logic [7:0]   dataIn,
  input  prog_mode_e   modeSel,
  input  logic         busy,
  input  ctrl_strobe_t strb,
  output logic [7:0]   dataOut,
  output logic         progErr
);

  localparam int DEPTH = 1 << AW;

  logic [7:0]    mem [DEPTH];
  logic [AW-1:0] wAddr;
  logic [7:0]    wData;
  logic          wIsLock;
  logic          wLockB;
  logic [1:0]    lockBits;
  logic [7:0]    cellNow;
  logic [7:0]    cellAtAddr;
  logic          pollHit;
  logic [7:0]    identAddr;

  assign cellNow    = mem[wAddr];
  assign cellAtAddr = mem[addr];
  assign pollHit    = busy && !wIsLock && (addr == wAddr);
  assign identAddr  = 8'(addr);

  // Pending operation registers
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wAddr   <= '0;
      wData   <= BLANK_BYTE;
      wIsLock <= 1'b0;
      wLockB  <= 1'b0;
    end else if (strb.latch) begin
      wAddr   <= addr;
      wData   <= dataIn;
      wIsLock <= (modeSel != MODE_WRITE);
      wLockB  <= (modeSel == MODE_LOCKB);
    end
  end

  // Non-blank target flag
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      progErr <= 1'b0;
    end else if (strb.eraseAll) begin
      progErr <= 1'b0;
    end else if (strb.latch && (modeSel == MODE_WRITE)) begin
      progErr <= (cellAtAddr != BLANK_BYTE);
    end
  end

  // Lock bits
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lockBits <= 2'b00;
    end else if (strb.eraseAll) begin
      lockBits <= 2'b00;
    end else if (strb.commit && wIsLock) begin
      lockBits[wLockB] <= 1'b1;
    end
  end

  // Cell array: commits only clear bits
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= BLANK_BYTE;
    end else if (strb.eraseAll) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= BLANK_BYTE;
    end else if (strb.commit && !wIsLock) begin
      mem[wAddr] <= cellNow & wData;
    end
  end

  // Read mux: polling, lock gating, identity block
  always_comb begin
    dataOut = BLANK_BYTE;
    case (modeSel)
      MODE_VERIFY: begin
        if (pollHit)               dataOut = {~wData[7], wData[6:0]};
        else if (lockBits != 2'b00) dataOut = BLANK_BYTE;
        else                       dataOut = cellAtAddr;
      end
      MODE_IDENT: dataOut = identByte(identAddr, HV_PART);
      default:    dataOut = BLANK_BYTE;
    endcase
  end

  AST_ONLY_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    (strb.commit && !wIsLock) |=> ((cellNow & ~$past(cellNow)) == 8'h00)); // R5
  AST_ERASE_BLANK: assert property (@(posedge clk) disable iff (!rstN)
    strb.eraseAll |=> ((cellNow == BLANK_BYTE) && (lockBits == 2'b00) && !progErr)); // R7
  AST_HOLD_TARGET: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !strb.commit) |=> ($stable(wAddr) && $stable(wData))); // R6
  AST_POLL_INVERT: assert property (@(posedge clk) disable iff (!rstN)
    (pollHit && (modeSel == MODE_VERIFY)) |-> (dataOut[7] != wData[7])); // R4
  AST_LOCK_HIDES: assert property (@(posedge clk) disable iff (!rstN)
    ((lockBits != 2'b00) && !busy && (modeSel == MODE_VERIFY)) |-> (dataOut == BLANK_BYTE)); // R8

endmodule

// File: rtl/flash_prog_seq.sv
module flash_prog_seq
  import flash_prog_pkg::*;
#(
  parameter int AW           = 6,
  parameter int WRITE_CYCLES = 1500,
  parameter int ERASE_CYCLES = 10000,
  parameter bit HV_PART      = 1'b1
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic [AW-1:0] addr,
  input  logic [7:0]    dataIn,
  input  logic [2:0]    mode,
  input  logic          hvEn,
  input  logic          progN,
  output logic [7:0]    dataOut,
  output logic          ready,
  output logic          progErr
);

  prog_mode_e   modeSel;
  logic         busy;
  ctrl_strobe_t strb;

  assign modeSel = prog_mode_e'(mode);
  assign ready   = ~busy;

  flash_prog_ctrl #(
    .WRITE_CYCLES(WRITE_CYCLES),
    .ERASE_CYCLES(ERASE_CYCLES)
  ) u_ctrl (
    .clk    (clk),
    .rstN   (rstN),
    .modeSel(modeSel),
    .hvEn   (hvEn),
    .progN  (progN),
    .busy   (busy),
    .strb   (strb)
  );

  flash_prog_dp #(
    .AW     (AW),
    .HV_PART(HV_PART)
  ) u_dp (
    .clk    (clk),
    .rstN   (rstN),
    .addr   (addr),
    .dataIn (dataIn),
    .modeSel(modeSel),
    .busy   (busy),
    .strb   (strb),
    .dataOut(dataOut),
    .progErr(progErr)
  );

  AST_IDLE_BLANK: assert property (@(posedge clk) disable iff (!rstN)
    ((modeSel != MODE_VERIFY) && (modeSel != MODE_IDENT)) |-> (dataOut == 8'hFF)); // R10

endmodule

// File: tb/flash_prog_seq_tb.sv
module flash_prog_seq_tb;

  localparam int CLK_PERIOD = 10;
  localparam int AW = 6;
  localparam int WC = 8;
  localparam int EC = 20;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [7:0]    dataIn = 8'h00;
  logic [2:0]    mode = 3'd0;
  logic          hvEn = 1'b0;
  logic          progN = 1'b1;
  logic [7:0]    dataOut;
  logic          ready;
  logic          progErr;

  flash_prog_seq #(.AW(AW), .WRITE_CYCLES(WC), .ERASE_CYCLES(EC), .HV_PART(1'b1)) u_dut (
    .clk(clk), .rstN(rstN), .addr(addr), .dataIn(dataIn), .mode(mode),
    .hvEn(hvEn), .progN(progN), .dataOut(dataOut), .ready(ready), .progErr(progErr)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  typedef struct {
    int         cyc;
    int         kind;   // 0 dataOut, 1 ready, 2 progErr
    logic [7:0] val;
    string      tag;
  } item_t;

  item_t expQ[$];
  int cycNo = 0;
  int nChecks = 0;
  int nFail = 0;
  bit finished = 1'b0;

  always @(posedge clk) cycNo <= cycNo + 1;

  // Monitor: compares queued expectations at the falling edge
  always @(negedge clk) begin
    item_t it;
    logic [7:0] act;
    while (expQ.size() > 0 && expQ[0].cyc == cycNo) begin
      it = expQ.pop_front();
      case (it.kind)
        0:       act = dataOut;
        1:       act = {7'b0, ready};
        default: act = {7'b0, progErr};
      endcase
      nChecks++;
      if (act !== it.val) begin
        nFail++;
        $display("FAIL %s kind=%0d actual=%h expected=%h", it.tag, it.kind, act, it.val);
      end
    end
  end

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic expect_(input int kind, input logic [7:0] val, input string tag);
    item_t it;
    it.cyc = cycNo; it.kind = kind; it.val = val; it.tag = tag;
    expQ.push_back(it);
  endtask

  task automatic readChk(input logic [AW-1:0] a, input logic [2:0] m,
                         input logic [7:0] exp, input string tag);
    mode = m; addr = a; hvEn = 1'b0;
    expect_(0, exp, tag);
    tick();
  endtask

  task automatic pulseProg(input logic [2:0] m, input logic [AW-1:0] a, input logic [7:0] d);
    mode = m; addr = a; dataIn = d; hvEn = 1'b1; progN = 1'b0;
    tick();
    progN = 1'b1;
    tick();
  endtask

  task automatic waitWindow(input string tag);
    for (int i = 0; i < WC; i++) begin
      expect_(1, 8'h00, tag);
      tick();
    end
    expect_(1, 8'h01, tag);
  endtask

  task automatic writeByte(input logic [AW-1:0] a, input logic [7:0] d,
                           input logic [7:0] expStored, input logic expErr, input string tag);
    pulseProg(3'd1, a, d);
    mode = 3'd2; hvEn = 1'b0;
    expect_(0, {~d[7], d[6:0]}, {tag, " R4 poll"});
    waitWindow({tag, " R2 window"});
    expect_(0, expStored, {tag, " R4 data"});
    expect_(2, {7'b0, expErr}, {tag, " R5 err"});
    tick();
  endtask

  task automatic eraseHold(input int n);
    mode = 3'd5; hvEn = 1'b1; progN = 1'b0;
    repeat (n) tick();
    progN = 1'b1; mode = 3'd0; hvEn = 1'b0;
    tick();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      nFail++;
      $display("FAIL watchdog expired");
      $display("  == %0d vectors applied, %0d miscompares ==", nChecks, nFail);
      $finish;
    end
  end

  initial begin
    repeat (3) tick();
    rstN = 1'b1;
    tick();
    // R1 reset state
    expect_(1, 8'h01, "R1 ready");
    expect_(2, 8'h00, "R1 err");
    tick();
    readChk(6'h05, 3'd2, 8'hFF, "R1 blank");

    // R2/R4 writes with both polarities of bit 7
    writeByte(6'h05, 8'hA5, 8'hA5, 1'b0, "R2 wr05");
    writeByte(6'h06, 8'h3C, 8'h3C, 1'b0, "R2 wr06");

    // R3 strobe without voltage, then in a non-programming mode
    mode = 3'd1; addr = 6'h07; dataIn = 8'h00; hvEn = 1'b0; progN = 1'b0;
    tick(); progN = 1'b1; tick();
    expect_(1, 8'h01, "R3 no hv");
    tick();
    mode = 3'd0; hvEn = 1'b1; progN = 1'b0;
    tick(); progN = 1'b1; tick();
    expect_(1, 8'h01, "R3 idle mode");
    tick();
    readChk(6'h07, 3'd2, 8'hFF, "R3 untouched");

    // R5 rewrite of non-blank byte, then blank write clears flag
    writeByte(6'h05, 8'h0F, 8'h05, 1'b1, "R5 rewrite");
    writeByte(6'h08, 8'h11, 8'h11, 1'b0, "R5 clear");

    // R6 strobe during busy is ignored
    pulseProg(3'd1, 6'h09, 8'h55);
    tick(); tick();
    addr = 6'h0A; dataIn = 8'h00; progN = 1'b0;
    tick(); progN = 1'b1; tick();
    repeat (WC - 1) tick();
    expect_(1, 8'h01, "R6 no restart");
    tick();
    readChk(6'h0A, 3'd2, 8'hFF, "R6 second target");
    readChk(6'h09, 3'd2, 8'h55, "R6 first target");

    // R10 blank output in other modes
    readChk(6'h05, 3'd0, 8'hFF, "R10 idle");
    readChk(6'h05, 3'd1, 8'hFF, "R10 write mode");

    // R9 identity reads
    readChk(6'h30, 3'd6, 8'h1E, "R9 id0");
    readChk(6'h31, 3'd6, 8'h51, "R9 id1");
    readChk(6'h32, 3'd6, 8'hFF, "R9 id2");
    readChk(6'h33, 3'd6, 8'hFF, "R9 other");

    // R7 short hold does nothing, full hold erases
    writeByte(6'h09, 8'h00, 8'h00, 1'b1, "R7 prep");
    eraseHold(EC - 1);
    readChk(6'h05, 3'd2, 8'h05, "R7 short hold");
    expect_(2, 8'h01, "R7 short err kept");
    tick();
    eraseHold(EC + 1);
    readChk(6'h05, 3'd2, 8'hFF, "R7 erased 05");
    readChk(6'h09, 3'd2, 8'hFF, "R7 erased 09");
    expect_(2, 8'h00, "R7 err cleared");
    tick();

    // R8 lock A hides data
    writeByte(6'h0B, 8'h77, 8'h77, 1'b0, "R8 prep A");
    pulseProg(3'd3, 6'h00, 8'h00);
    mode = 3'd0; hvEn = 1'b0;
    waitWindow("R8 lockA window");
    tick();
    readChk(6'h0B, 3'd2, 8'hFF, "R8 lockA hides");
    readChk(6'h31, 3'd6, 8'h51, "R9 under lock");
    eraseHold(EC + 1);
    writeByte(6'h0B, 8'h12, 8'h12, 1'b0, "R8 prep B");
    pulseProg(3'd4, 6'h00, 8'h00);
    mode = 3'd0; hvEn = 1'b0;
    waitWindow("R8 lockB window");
    tick();
    readChk(6'h0B, 3'd2, 8'hFF, "R8 lockB hides");
    eraseHold(EC + 1);
    writeByte(6'h0C, 8'h42, 8'h42, 1'b0, "R8 unlocked again");

    tick(); tick();
    finished = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", nChecks, nFail);
    $finish;
  end

endmodule